// File: doc/BRIEF.md
# Inertial Sensor Bring-Up Sequencer

This block drives the power-up and reconfiguration sequence of an inertial sensor through a simple register-write request port. A serial frame engine consumes the requests. When reset is released, the block starts one sequence on its own. It also starts one when a start pulse arrives while it is idle or ready. Each sequence first sends the sensor's soft-reset command and then waits for the digital core to start up. Next it writes a single configuration word, which carries the two filter-bandwidth choices and the self-test repetition count. It then waits out a settling time that grows with the repetition count, and finally raises a ready flag.

The sensor accepts its configuration only once after each reset. Because of this, every change of bandwidth or self-test count repeats the whole sequence, soft reset included. All delays are counted in clock cycles from a cycles-per-millisecond parameter. A bench can therefore shorten every wait by the same factor. The bandwidth and count inputs are captured when a sequence is accepted. A start request with an illegal repetition count is refused and sets an error flag, and no write is issued for it.

Top module: `imu_bringup_seq`

## Requirements
- R1: While reset is held, all outputs are low. In the first cycle after reset is released, the block raises a write request without any start pulse.
- R2: The first write of every sequence goes to address 0x2F with data 0x00B6.
- R3: The soft-reset write completes in the cycle where `wr_ready_i` is high. From that point the block waits exactly 120 × CYC_PER_MS cycles, and the configuration write request rises in the next cycle.
- R4: The configuration write goes to address 0x0A. Its data bits are laid out as follows: bit 0 = 1, bit 1 = gyro bandwidth select, bit 2 = accel bandwidth select, bit 3 = 1 (automatic self-test), bits 6:4 = repetition count minus one, and bits 15:7 = 0.
- R5: On a bandwidth input, a 1 selects the 50 Hz filter and a 0 selects the 400 Hz filter. The value is copied unchanged into its configuration bit.
- R6: The configuration write completes when `wr_ready_i` is high. After that the block waits exactly (160 + 140 × count) × CYC_PER_MS cycles, then drops `busy_o` and raises `ready_o` in the same cycle.
- R7: A write request stays asserted until `wr_ready_i` is high, and its address and data stay stable while it waits.
- R8: A start with a repetition count of 0 or above 8 sets `err_o`, issues no write, keeps `busy_o` low and drops `ready_o`. The next accepted start clears `err_o`.
- R9: `busy_o` is high from the cycle after an accepted start until the final wait ends. Start pulses and input changes during that time have no effect on the sequence.
- R10: A start pulse while `ready_o` is high reruns the complete sequence, beginning with the soft-reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new bring-up sequence |
| accel_bw_i | input | 1 | Accel filter: 1 = 50 Hz, 0 = 400 Hz |
| gyro_bw_i | input | 1 | Gyro filter: 1 = 50 Hz, 0 = 400 Hz |
| reps_i | input | 4 | Self-test repetition count, legal range 1..8 |
| wr_valid_o | output | 1 | Register-write request to the frame engine |
| wr_ready_i | input | 1 | Frame engine accepts the request |
| wr_addr_o | output | 8 | Register address of the request |
| wr_data_o | output | 16 | Register data of the request |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Sensor configured and settled |
| err_o | output | 1 | Last start refused for an illegal count |

## Verification
Every output of this block depends only on the sequencer's state, so any wrong state appears at the ports in the same cycle. A wrong phase shows up as a request, busy or ready level that does not match. A wrong captured field shows up in the configuration data. A wrong timer value shows up as a shifted request edge or a shifted ready edge. If a wait is off by a single cycle, the error is visible at the end of that wait, no later.

// File: rtl/imu_bringup_seq.sv
module imu_bringup_seq #(
  parameter int unsigned CYC_PER_MS  = 100000,
  parameter int unsigned STARTUP_MS  = 120,
  parameter int unsigned MECH_MS     = 100,
  parameter int unsigned SELFTEST_MS = 140,
  parameter int unsigned FLUSH_MS    = 60,
  parameter int unsigned MAX_REPS    = 8,
  parameter logic [7:0]  CMD_ADDR    = 8'h2F,
  parameter logic [15:0] RST_CODE    = 16'h00B6,
  parameter logic [7:0]  CFG_ADDR    = 8'h0A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        accel_bw_i,
  input  logic        gyro_bw_i,
  input  logic [3:0]  reps_i,
  output logic        wr_valid_o,
  input  logic        wr_ready_i,
  output logic [7:0]  wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        busy_o,
  output logic        ready_o,
  output logic        err_o
);
  localparam int unsigned FW      = 3;
  localparam int unsigned MAX_CYC = (MECH_MS + FLUSH_MS + SELFTEST_MS * MAX_REPS) * CYC_PER_MS;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] RST_CYC  = CW'(STARTUP_MS * CYC_PER_MS);
  localparam logic [CW-1:0] BASE_CYC = CW'((MECH_MS + FLUSH_MS) * CYC_PER_MS);
  localparam logic [CW-1:0] STEP_CYC = CW'(SELFTEST_MS * CYC_PER_MS);

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_RST_WR, S_RST_WAIT, S_CFG_WR, S_CFG_WAIT, S_READY
  } state_t;

  state_t          state;
  logic [CW-1:0]   timer;
  logic            acc_q, gyr_q, err_q;
  logic [FW-1:0]   reps_q;

  logic [3:0]      reps_m1;
  logic            reps_ok, launch;
  logic [CW-1:0]   cfg_cycles;

  assign reps_m1    = reps_i - 4'd1;
  assign reps_ok    = (reps_i != 4'd0) && (reps_i <= 4'(MAX_REPS));
  assign launch     = (state == S_BOOT) ||
                      (((state == S_IDLE) || (state == S_READY)) && start_i);
  assign cfg_cycles = BASE_CYC + STEP_CYC * (CW'(reps_q) + ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_BOOT;
      timer  <= '0;
      acc_q  <= 1'b0;
      gyr_q  <= 1'b0;
      reps_q <= '0;
      err_q  <= 1'b0;
    end else if (launch) begin
      if (reps_ok) begin
        acc_q  <= accel_bw_i;
        gyr_q  <= gyro_bw_i;
        reps_q <= reps_m1[FW-1:0];
        err_q  <= 1'b0;
        state  <= S_RST_WR;
      end else begin
        err_q  <= 1'b1;
        state  <= S_IDLE;
      end
    end else begin
      case (state)
        S_RST_WR:
          if (wr_ready_i) begin
            timer <= RST_CYC - ONE;
            state <= S_RST_WAIT;
          end
        S_RST_WAIT:
          if (timer == '0) state <= S_CFG_WR;
          else             timer <= timer - ONE;
        S_CFG_WR:
          if (wr_ready_i) begin
            timer <= cfg_cycles - ONE;
            state <= S_CFG_WAIT;
          end
        S_CFG_WAIT:
          if (timer == '0) state <= S_READY;
          else             timer <= timer - ONE;
        default: ;
      endcase
    end
  end

  assign wr_valid_o = (state == S_RST_WR) || (state == S_CFG_WR);
  assign wr_addr_o  = (state == S_CFG_WR) ? CFG_ADDR : CMD_ADDR;
  assign wr_data_o  = (state == S_CFG_WR) ?
                      {9'd0, reps_q, 1'b1, acc_q, gyr_q, 1'b1} : RST_CODE;
  assign busy_o     = (state == S_RST_WR) || (state == S_RST_WAIT) ||
                      (state == S_CFG_WR) || (state == S_CFG_WAIT);
  assign ready_o    = (state == S_READY);
  assign err_o      = err_q;
endmodule

// File: rtl/imu_bringup_seq_chk.sv
module imu_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid_o,
  input logic        wr_ready_i,
  input logic [7:0]  wr_addr_o,
  input logic [15:0] wr_data_o,
  input logic        busy_o,
  input logic        ready_o,
  input logic        err_o
);
  AST_SOFT_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> wr_valid_o && wr_addr_o == 8'h2F && wr_data_o == 16'h00B6); // R2
  AST_CFG_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_addr_o == 8'h0A) |-> (wr_data_o[0] && wr_data_o[3] && wr_data_o[15:7] == 9'd0)); // R4
  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !wr_valid_o && !ready_o)); // R8
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o); // R9
  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !busy_o); // R6
  AST_READY_FOLLOWS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(busy_o) && !$past(wr_valid_o))); // R6
endmodule

bind imu_bringup_seq imu_bringup_seq_chk i_chk (.*);

// File: tb/test_imu_bringup_seq.sv
module test_imu_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 2;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, acc = 1'b0, gyr = 1'b0;
  logic [3:0] reps = 4'd3;
  logic wr_ready = 1'b0;
  logic wr_valid, busy, ready, err;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;

  int checks = 0, failures = 0, cycles = 0;
  bit hold_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imu_bringup_seq #(.CYC_PER_MS(CPM)) i_imu_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .accel_bw_i(acc), .gyro_bw_i(gyr),
    .reps_i(reps), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy), .ready_o(ready), .err_o(err));

  // behavioural model: phase 0 boot, 1 idle, 2 reset write, 3 reset wait,
  // 4 config write, 5 settle wait, 6 ready
  int ph = 0, rem = 0, m_reps = 3;
  bit m_err = 0, m_acc = 0, m_gyr = 0, launch;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ph = 0; m_err = 0;
    end else begin
      launch = (ph == 0) || ((ph == 1 || ph == 6) && start);
      if (launch) begin
        if (reps >= 1 && reps <= 8) begin
          m_acc = acc; m_gyr = gyr; m_reps = int'(reps); m_err = 0; ph = 2;
        end else begin
          m_err = 1; ph = 1;
        end
      end else if (ph == 2) begin
        if (wr_ready) begin ph = 3; rem = 120 * CPM; end
      end else if (ph == 3) begin
        rem--; if (rem == 0) ph = 4;
      end else if (ph == 4) begin
        if (wr_ready) begin ph = 5; rem = (100 + 140 * m_reps + 60) * CPM; end
      end else if (ph == 5) begin
        rem--; if (rem == 0) ph = 6;
      end
    end
  end

  function automatic int cfg_word(bit a, bit g, int n);
    return 1 | (int'(g) << 1) | (int'(a) << 2) | 8 | ((n - 1) << 4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    bit ev, eb;
    ev = (ph == 2) || (ph == 4);
    eb = (ph >= 2) && (ph <= 5);
    chk(wr_valid == ev, (ph == 3 || ph == 4) ? "R3" : "R7", "wr_valid", int'(wr_valid), int'(ev));
    chk(busy == eb, "R9", "busy", int'(busy), int'(eb));
    chk(ready == (ph == 6), "R6", "ready", int'(ready), int'(ph == 6));
    chk(err == m_err, "R8", "err", int'(err), int'(m_err));
    if (ev && ph == 2) begin
      chk(wr_addr == 8'h2F, "R2", "reset addr", int'(wr_addr), 'h2F);
      chk(wr_data == 16'h00B6, "R2", "reset data", int'(wr_data), 'hB6);
    end
    if (ev && ph == 4) begin
      chk(wr_addr == 8'h0A, "R4", "config addr", int'(wr_addr), 'h0A);
      chk(int'(wr_data) == cfg_word(m_acc, m_gyr, m_reps), "R4", "config data",
          int'(wr_data), cfg_word(m_acc, m_gyr, m_reps));
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      wr_ready = hold_ready ? 1'b0 : ((cycles % 3) != 1);
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles >= WATCHDOG);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    summary();
  end

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_ready(output int seen_cfg);
    seen_cfg = -1;
    while (!ready) begin
      @(negedge clk);
      if (wr_valid && wr_addr == 8'h0A) seen_cfg = int'(wr_data);
    end
  endtask

  task automatic run_seq(input bit a, input bit g, input int n);
    int seen;
    @(negedge clk); acc = a; gyr = g; reps = 4'(n);
    pulse_start();
    chk(busy && wr_addr == 8'h2F, "R10", "rerun starts with reset write", int'(wr_addr), 'h2F);
    wait_ready(seen);
    chk(seen == cfg_word(a, g, n), "R5", "bandwidth bits in config word", seen, cfg_word(a, g, n));
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !ready && !err, "R1", "outputs in reset",
        {wr_valid, busy, ready, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_valid && wr_addr == 8'h2F, "R1", "auto launch after reset", int'(wr_addr), 'h2F);
    wait_ready(seen);
    chk(seen == 'h0029, "R4", "default config word", seen, 'h0029);

    run_seq(1'b1, 1'b0, 1);
    run_seq(1'b0, 1'b1, 8);
    run_seq(1'b1, 1'b1, 5);

    // refused counts
    @(negedge clk); reps = 4'd0;
    pulse_start();
    chk(err && !busy && !wr_valid && !ready, "R8", "count 0 refused", {err, busy, wr_valid}, 4);
    @(negedge clk); reps = 4'd9;
    pulse_start();
    chk(err && !wr_valid, "R8", "count 9 refused", int'(err), 1);
    @(negedge clk); reps = 4'd15;
    pulse_start();
    repeat (5) @(negedge clk);
    chk(err && !busy, "R8", "count 15 refused, stays quiet", int'(busy), 0);
    run_seq(1'b0, 1'b0, 2);
    chk(!err, "R8", "accepted start clears error", int'(err), 0);

    // start and input changes while busy are ignored; stalled handshake
    @(negedge clk); acc = 1'b1; gyr = 1'b0; reps = 4'd4; hold_ready = 1'b1;
    pulse_start();
    repeat (8) @(negedge clk);
    chk(wr_valid && wr_addr == 8'h2F, "R7", "request held while stalled", int'(wr_addr), 'h2F);
    hold_ready = 1'b0;
    repeat (20) @(negedge clk);
    acc = 1'b0; gyr = 1'b1; reps = 4'd7;
    pulse_start();
    wait_ready(seen);
    chk(seen == cfg_word(1'b1, 1'b0, 4), "R9", "inputs during busy ignored", seen, cfg_word(1'b1, 1'b0, 4));

    run_seq(1'b0, 1'b1, 3);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule